// File: doc/BRIEF.md
# Transfer-End Chaining and Interrupt Controller

This block makes the end-of-transfer decisions for a descriptor-driven data transfer controller. Each time one unit of data has moved, the mover pulses a done strobe and presents the descriptor's mode byte and its current transfer count. The block decrements the count and tests the new value for zero. It then decides four things: whether to chain to the next descriptor, whether to clear the activation source flag and the channel enable, whether to raise a CPU interrupt, and which address (source or destination) is the repeat or block area to be reloaded.

Chaining can be switched off, taken after every transfer, or taken only when the count has just reached zero. A chain that is taken suppresses the completion check, so no flag clear, no enable clear and no completion interrupt are produced for that transfer. The mode byte is never written by software. It arrives only as part of a fetched descriptor and has no defined value until one is loaded. All decisions come out as one-cycle pulses registered on the edge after the done strobe.

Top module: `xfer_end_ctrl`

## Requirements
- R1: A synchronous active-high reset drives every pulse output and the count output to zero.
- R2: Every decision output is a single-cycle pulse in the cycle after a done strobe. With no done strobe in the previous cycle, all pulse outputs are low.
- R3: On each done strobe the count output takes the input count minus one, registered. An input count of zero wraps to all ones, and the zero test uses the decremented value.
- R4: With mode bit 7 = 0, chain_req never asserts.
- R5: With mode bit 7 = 1 and bit 6 = 0, chain_req asserts after every transfer.
- R6: With mode bit 7 = 1 and bit 6 = 1, chain_req asserts only when the decremented count is zero.
- R7: When chain_req asserts, flag_clr and en_clr stay low, even if the count reached zero.
- R8: With mode bit 5 = 1, irq asserts after every transfer. This includes transfers that chain, in which case chain_req and irq assert in the same cycle.
- R9: With mode bit 5 = 0, irq asserts only when no chain is taken and the decremented count is zero. In that case flag_clr and en_clr assert in the same cycle as irq.
- R10: Mode bit 4 = 1 pulses area_src, and bit 4 = 0 pulses area_dst. Exactly one of the two pulses per done strobe.
- R11: Mode bits 3..0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| done_i | input | 1 | One-cycle strobe: one data unit has moved |
| mode_i | input | 8 | Descriptor mode byte, valid with done_i |
| count_i | input | CNT_W | Transfer count before this transfer, valid with done_i |
| chain_req_o | output | 1 | Pulse: fetch and run the next descriptor |
| flag_clr_o | output | 1 | Pulse: clear the activation source flag |
| en_clr_o | output | 1 | Pulse: clear the channel enable |
| irq_o | output | 1 | Pulse: CPU interrupt request |
| area_src_o | output | 1 | Pulse: the source is the repeat/block area |
| area_dst_o | output | 1 | Pulse: the destination is the repeat/block area |
| count_o | output | CNT_W | Decremented count, updated on each done strobe |

## Verification
Every result, pulses and count alike, is due exactly one clock edge after the edge that samples done_i. No result has a deeper path than that.

The bench drives inputs on falling edges and holds done_i high for exactly one rising edge. It reads the outputs at the next falling edge, where the registered result is stable. One falling edge later it checks that every pulse has dropped again.

The count sets used are chosen so that the decremented value lands on zero, on a non-zero value, and on the wrap from zero.

// File: rtl/xec_pkg.sv
package xec_pkg;

  // Positions of the mode byte fields
  localparam int MB_CHAIN_EN   = 7;
  localparam int MB_CHAIN_ZERO = 6;
  localparam int MB_IRQ_EACH   = 5;
  localparam int MB_AREA_SRC   = 4;

  typedef struct packed {
    logic chain;
    logic flag_clr;
    logic en_clr;
    logic irq;
    logic area_src;
    logic area_dst;
  } xec_act_t;

  // Chaining rule: enabled, and either unconditional or count hit zero
  function automatic logic chain_rule(input logic en, input logic on_zero,
                                      input logic zero);
    return en & (~on_zero | zero);
  endfunction

  // Completion: only checked when no chain is taken
  function automatic logic end_rule(input logic chain, input logic zero);
    return ~chain & zero;
  endfunction

  // Interrupt: every transfer, or only on completion
  function automatic logic irq_rule(input logic each, input logic ended);
    return each | ended;
  endfunction

endpackage

// File: rtl/xec_counter.sv
module xec_counter #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] dec_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] dec_fn(input logic [CNT_W-1:0] c);
    return c - ONE;
  endfunction

  always_comb begin
    dec_o  = dec_fn(count_i);
    zero_o = (dec_o == '0);
  end
endmodule

// File: rtl/xec_decide.sv
module xec_decide
  import xec_pkg::*;
(
  input  logic [7:0] mode_i,
  input  logic       zero_i,
  output xec_act_t   act_o,
  output logic       chain_take_o,
  output logic       end_reached_o
);
  logic unused_mode_low;
  assign unused_mode_low = ^mode_i[3:0];

  always_comb begin
    chain_take_o   = chain_rule(mode_i[MB_CHAIN_EN], mode_i[MB_CHAIN_ZERO], zero_i);
    end_reached_o  = end_rule(chain_take_o, zero_i);
    act_o.chain    = chain_take_o;
    act_o.flag_clr = end_reached_o;
    act_o.en_clr   = end_reached_o;
    act_o.irq      = irq_rule(mode_i[MB_IRQ_EACH], end_reached_o);
    act_o.area_src = mode_i[MB_AREA_SRC];
    act_o.area_dst = ~mode_i[MB_AREA_SRC];
  end
endmodule

// File: rtl/xec_pulse_reg.sv
module xec_pulse_reg
  import xec_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire_i,
  input  xec_act_t         act_i,
  input  logic [CNT_W-1:0] dec_i,
  output xec_act_t         act_q,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      cnt_q <= '0;
    end else begin
      act_q <= fire_i ? act_i : '0;
      if (fire_i) cnt_q <= dec_i;
    end
  end

  // R2: without a strobe, nothing pulses
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !fire_i |=> (act_q == '0));
  // R10: exactly one area strobe per transfer
  p_area_one_r10: assert property (@(posedge clk) disable iff (rst)
    fire_i |=> (act_q.area_src ^ act_q.area_dst));
endmodule

// File: rtl/xfer_end_ctrl.sv
module xfer_end_ctrl
  import xec_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_i,
  input  logic [7:0]       mode_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             chain_req_o,
  output logic             flag_clr_o,
  output logic             en_clr_o,
  output logic             irq_o,
  output logic             area_src_o,
  output logic             area_dst_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] dec_cnt;
  logic             cnt_zero;
  logic             chain_take;
  logic             end_reached;
  xec_act_t         act_d, act_q;

  xec_counter #(.CNT_W(CNT_W)) u_cnt (
    .count_i(count_i), .dec_o(dec_cnt), .zero_o(cnt_zero)
  );

  xec_decide u_dec (
    .mode_i(mode_i), .zero_i(cnt_zero), .act_o(act_d),
    .chain_take_o(chain_take), .end_reached_o(end_reached)
  );

  xec_pulse_reg #(.CNT_W(CNT_W)) u_reg (
    .clk(clk), .rst(rst), .fire_i(done_i), .act_i(act_d),
    .dec_i(dec_cnt), .act_q(act_q), .cnt_q(count_o)
  );

  assign chain_req_o = act_q.chain;
  assign flag_clr_o  = act_q.flag_clr;
  assign en_clr_o    = act_q.en_clr;
  assign irq_o       = act_q.irq;
  assign area_src_o  = act_q.area_src;
  assign area_dst_o  = act_q.area_dst;

  // R4: chaining disabled means no chain
  p_no_chain_r4: assert property (@(posedge clk) disable iff (rst)
    (done_i && !mode_i[7]) |=> !chain_req_o);
  // R7: a chain suppresses flag and enable clearing
  p_chain_no_clr_r7: assert property (@(posedge clk) disable iff (rst)
    chain_req_o |-> (!flag_clr_o && !en_clr_o));
  // R8: per-transfer interrupt
  p_irq_each_r8: assert property (@(posedge clk) disable iff (rst)
    (done_i && mode_i[5]) |=> irq_o);
  // R9: completion clears come together with the interrupt
  p_clr_pair_r9: assert property (@(posedge clk) disable iff (rst)
    flag_clr_o |-> (en_clr_o && irq_o));
  // R3: count output moves only on a strobe
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !done_i |=> $stable(count_o));
  // R9: completion only when the count is zero
  p_clr_zero_r9: assert property (@(posedge clk) disable iff (rst)
    flag_clr_o |-> (count_o == '0));
endmodule

// File: tb/sim_xfer_end_ctrl.sv
module sim_xfer_end_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic done_i = 1'b0;
  logic [7:0] mode_i = 8'h00;
  logic [CNT_W-1:0] count_i = '0;
  logic chain_req_o, flag_clr_o, en_clr_o, irq_o, area_src_o, area_dst_o;
  logic [CNT_W-1:0] count_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_end_ctrl #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .done_i(done_i), .mode_i(mode_i), .count_i(count_i),
    .chain_req_o(chain_req_o), .flag_clr_o(flag_clr_o), .en_clr_o(en_clr_o),
    .irq_o(irq_o), .area_src_o(area_src_o), .area_dst_o(area_dst_o),
    .count_o(count_o)
  );

  function automatic logic [5:0] pulses();
    return {chain_req_o, flag_clr_o, en_clr_o, irq_o, area_src_o, area_dst_o};
  endfunction

  task automatic check6(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pulses {chain,fclr,eclr,irq,src,dst} actual %b expected %b",
               tag, act, exp);
    end
  endtask

  task automatic checkc(input string tag, input logic [CNT_W-1:0] act,
                        input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s count actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One transfer: strobe for one edge, read the result, then check it drops
  task automatic xfer(input string tag, input logic [7:0] m, input logic [CNT_W-1:0] c,
                      input logic [5:0] exp);
    @(negedge clk);
    done_i = 1'b1; mode_i = m; count_i = c;
    @(negedge clk);
    done_i = 1'b0; mode_i = 8'h00; count_i = '0;
    check6(tag, pulses(), exp);
    checkc(tag, count_o, c - 8'd1);
    @(negedge clk);
    check6({tag, " R2 drop"}, pulses(), 6'b000000);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check6("R1 reset", pulses(), 6'b000000);
    checkc("R1 reset", count_o, '0);
    rst = 1'b0;
    @(negedge clk);
    check6("R2 idle", pulses(), 6'b000000);
  endtask

  task automatic t_no_chain;
    xfer("R4 mid", 8'h00, 8'd5, 6'b000001);
    xfer("R9 end", 8'h00, 8'd1, 6'b011101);
    xfer("R4 end irq-each", 8'h60, 8'd1, 6'b011101);
  endtask

  task automatic t_chain_always;
    xfer("R5 mid", 8'h80, 8'd5, 6'b100001);
    xfer("R7 end", 8'h80, 8'd1, 6'b100001);
  endtask

  task automatic t_chain_on_zero;
    xfer("R6 mid", 8'hC0, 8'd5, 6'b000001);
    xfer("R6 end", 8'hC0, 8'd1, 6'b100001);
  endtask

  task automatic t_irq_each;
    xfer("R8 mid", 8'h20, 8'd5, 6'b000101);
    xfer("R8 chain", 8'hA0, 8'd5, 6'b100101);
    xfer("R8 chain end", 8'hE0, 8'd1, 6'b100101);
  endtask

  task automatic t_area;
    xfer("R10 src", 8'h10, 8'd3, 6'b000010);
    xfer("R10 src end", 8'h30, 8'd1, 6'b011110);
  endtask

  task automatic t_wrap_and_low;
    xfer("R3 wrap", 8'h00, 8'd0, 6'b000001);
    xfer("R11 low bits", 8'h0F, 8'd1, 6'b011101);
    xfer("R11 low bits chain", 8'hCF, 8'd7, 6'b000001);
  endtask

  task automatic t_hold;
    xfer("R3 set", 8'h00, 8'd9, 6'b000001);
    count_i = 8'd77;
    repeat (3) @(negedge clk);
    checkc("R3 hold", count_o, 8'd8);
  endtask

  initial begin
    t_reset();
    t_no_chain();
    t_chain_always();
    t_chain_on_zero();
    t_irq_each();
    t_area();
    t_wrap_and_low();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule